// File: doc/BRIEF.md
# Card-to-host stream packet framer

The framer turns payload packets from the user side into beats on an AXI4-Stream port that feeds a card-to-host DMA channel. The user first hands over a request: a byte length, a queue number, a port number, a completion flag and a marker flag. The user then streams the payload as full-width words on a separate valid/ready input. The framer emits one output beat per payload word. It marks the final beat with last, gives the count of unused bytes in that beat, and attaches a running CRC-32 that a receiver takes only on the final beat.

The request fields are held as a sideband control bundle for the whole packet, together with a 7-bit SECDED check code over a fixed 57-bit packing of those fields. A zero-byte request still produces one beat. A request longer than 31 host buffers is dropped and flagged, and no beat is framed for it.

Top module: `c2h_framer`

## Requirements
- R1: An output beat is transferred only on a cycle where outValid and outReady are both high. While outValid is high and outReady is low, every output holds its value and outValid stays high.
- R2: A request of length L > 0 is framed as ceil(L / (DATA_W/8)) beats. Each beat takes one payload word from the input stream. outLast is high on the final beat only.
- R3: Payload byte k of a beat is bits [8k+7:8k] of outData and is copied from the same bits of the input word.
- R4: outMty is 6 bits wide. It is 0 on every beat except the last. On the last beat it equals the number of bytes in that beat that lie beyond the packet length.
- R5: A zero-length request produces exactly one beat with outLast high, outMty equal to DATA_W/8 - 1 and outCrc equal to 0. It consumes no payload word.
- R6: On the last beat, outCrc is the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, final XOR all ones) of the packet's valid bytes only, fed in ascending byte order with the least significant bit of each byte first. The CRC restarts for every packet.
- R7: outLen, outQid (12 bits), outPort (3 bits), outCmpt and outMarker equal the values given with the request, on every beat of that packet.
- R8: outEcc is {overall parity, p5..p0} of an extended Hamming code over the 57-bit word {24'b0, cmpt, marker, port[2:0], qid[11:0], len[15:0]}. Word bit j sits at the j-th codeword position in 1..63 that is not a power of two. p_k is the XOR of the word bits at positions with bit k set. The overall parity is the XOR of all 57 bits and p0..p5.
- R9: A request with length above 31 * BUF_BYTES pulses reqReject in the cycle it is accepted. It produces no beat and consumes no payload word.
- R10: reqReady is low whenever outValid is high, so a new request never alters the fields of a beat still on offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be taken |
| reqReject | output | 1 | Accepted request dropped for excess length |
| reqLen | input | 16 | Packet length in bytes |
| reqQid | input | 12 | Queue number |
| reqPort | input | 3 | Port number |
| reqCmpt | input | 1 | A completion follows this packet |
| reqMarker | input | 1 | Pipeline-flush marker |
| inValid | input | 1 | Payload word offered |
| inReady | output | 1 | Payload word taken |
| inData | input | DATA_W | Payload word, byte 0 in the low bits |
| outValid | output | 1 | Stream beat valid |
| outReady | input | 1 | Stream beat accepted downstream |
| outData | output | DATA_W | Stream beat data |
| outLast | output | 1 | Final beat of the packet |
| outMty | output | 6 | Unused bytes in the final beat |
| outCrc | output | 32 | CRC-32, meaningful on the final beat |
| outLen | output | 16 | Sideband length |
| outQid | output | 12 | Sideband queue number |
| outPort | output | 3 | Sideband port number |
| outCmpt | output | 1 | Sideband completion flag |
| outMarker | output | 1 | Sideband marker flag |
| outEcc | output | 7 | SECDED check code over the sideband fields |

## Verification
The hardest case to reach is a stall on the final beat while the next request is already waiting. The CRC, empty count and sideband fields must all hold under back-pressure, and the waiting request must not slip in early. The stimulus queues requests back to back, including a rejected one between accepted ones and lengths at and just past the 31-buffer limit. It also withholds outReady at random on most cycles, so final beats are often held for several cycles while reqValid is high.

// File: rtl/c2h_pkg.sv
package c2h_pkg;

  localparam int LEN_W  = 16;
  localparam int QID_W  = 12;
  localparam int PORT_W = 3;
  localparam int MTY_W  = 6;
  localparam int ECC_W  = 7;
  localparam int CRC_W  = 32;
  localparam int CW_W   = 57;

  typedef struct packed {
    logic loadReq;
    logic loadBeat;
    logic beatLast;
    logic zeroBeat;
  } strobe_t;

  // Extended Hamming (64,57): word bits fill non-power-of-two positions.
  function automatic logic [ECC_W-1:0] secded57(input logic [CW_W-1:0] word);
    logic [63:0] code;
    logic [5:0]  par;
    int          j;
    code = '0;
    par  = '0;
    j    = 0;
    for (int pos = 1; pos < 64; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        code[pos] = word[j];
        j++;
      end
    end
    for (int k = 0; k < 6; k++) begin
      for (int pos = 1; pos < 64; pos++) begin
        if (((pos >> k) & 1) == 1) par[k] = par[k] ^ code[pos];
      end
    end
    return {(^word) ^ (^par), par};
  endfunction

endpackage

// File: rtl/c2h_ctrl.sv
module c2h_ctrl
  import c2h_pkg::*;
#(
  parameter int BYTES   = 8,
  parameter int MAX_LEN = 1984
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             inValid,
  input  logic             outValid,
  input  logic             outReady,
  output logic             reqReady,
  output logic             reqReject,
  output logic             inReady,
  output strobe_t          strobe
);

  localparam int LOG2B  = $clog2(BYTES);
  localparam int BEAT_W = LEN_W - LOG2B + 1;

  typedef enum logic {ST_IDLE, ST_SEND} state_t;

  state_t            state;
  logic [BEAT_W-1:0] beatsLeft;
  logic              zeroPkt;
  logic              slotFree;
  logic              accept;
  logic              tooLong;
  logic [BEAT_W-1:0] beatsNeeded;

  assign slotFree    = !outValid || outReady;
  assign reqReady    = (state == ST_IDLE) && !outValid;
  assign accept      = reqValid && reqReady;
  assign tooLong     = int'(reqLen) > MAX_LEN;
  assign reqReject   = accept && tooLong;
  assign inReady     = (state == ST_SEND) && !zeroPkt && slotFree;
  assign beatsNeeded = BEAT_W'(reqLen >> LOG2B) + BEAT_W'(|reqLen[LOG2B-1:0]);

  always_comb begin
    strobe.loadReq  = accept && !tooLong;
    strobe.loadBeat = (state == ST_SEND) && slotFree && (zeroPkt || inValid);
    strobe.beatLast = zeroPkt || (beatsLeft == BEAT_W'(1));
    strobe.zeroBeat = zeroPkt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      beatsLeft <= '0;
      zeroPkt   <= 1'b0;
    end else begin
      if (strobe.loadReq) begin
        state     <= ST_SEND;
        zeroPkt   <= (reqLen == '0);
        beatsLeft <= (reqLen == '0) ? BEAT_W'(1) : beatsNeeded;
      end else if (strobe.loadBeat) begin
        beatsLeft <= beatsLeft - BEAT_W'(1);
        if (strobe.beatLast) begin
          state   <= ST_IDLE;
          zeroPkt <= 1'b0;
        end
      end
    end
  end

  // R9: a dropped request leaves the framer idle with nothing on offer
  assert_reject_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqReject |=> (state == ST_IDLE) && !outValid);

  // R2: the beat counter never runs out while a packet is open
  assert_beats_live_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND) |-> (beatsLeft != '0));

  // R5: a zero-length packet consumes no payload word
  assert_zero_no_input_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND) && zeroPkt |-> !inReady);

endmodule

// File: rtl/c2h_datapath.sv
module c2h_datapath
  import c2h_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [QID_W-1:0]  reqQid,
  input  logic [PORT_W-1:0] reqPort,
  input  logic              reqCmpt,
  input  logic              reqMarker,
  input  logic [DATA_W-1:0] inData,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic [MTY_W-1:0]  outMty,
  output logic [CRC_W-1:0]  outCrc,
  output logic [LEN_W-1:0]  outLen,
  output logic [QID_W-1:0]  outQid,
  output logic [PORT_W-1:0] outPort,
  output logic              outCmpt,
  output logic              outMarker,
  output logic [ECC_W-1:0]  outEcc
);

  localparam int BYTES = DATA_W / 8;
  localparam int LOG2B = $clog2(BYTES);
  localparam int NB_W  = $clog2(BYTES + 1);
  localparam logic [CRC_W-1:0] POLY = 32'hEDB88320;

  logic [CRC_W-1:0] crcAcc;
  logic [CRC_W-1:0] crcNext;
  logic [NB_W-1:0]  nBytes;
  logic [LOG2B-1:0] tailBytes;

  function automatic logic [CRC_W-1:0] crcBytes(input logic [CRC_W-1:0] seed,
                                                input logic [DATA_W-1:0] word,
                                                input logic [NB_W-1:0]   count);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = seed;
    for (int i = 0; i < BYTES; i++) begin
      if (i < int'(count)) begin
        for (int b = 0; b < 8; b++) begin
          fb = c[0] ^ word[8*i+b];
          c  = c >> 1;
          if (fb) c = c ^ POLY;
        end
      end
    end
    return c;
  endfunction

  assign tailBytes = outLen[LOG2B-1:0];

  always_comb begin
    if (strobe.zeroBeat) nBytes = '0;
    else if (strobe.beatLast && tailBytes != '0) nBytes = NB_W'(tailBytes);
    else nBytes = NB_W'(BYTES);
  end

  assign crcNext = crcBytes(crcAcc, inData, nBytes);
  assign outEcc  = secded57({24'b0, outCmpt, outMarker, outPort, outQid, outLen});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLen    <= '0;
      outQid    <= '0;
      outPort   <= '0;
      outCmpt   <= 1'b0;
      outMarker <= 1'b0;
      crcAcc    <= '1;
    end else if (strobe.loadReq) begin
      outLen    <= reqLen;
      outQid    <= reqQid;
      outPort   <= reqPort;
      outCmpt   <= reqCmpt;
      outMarker <= reqMarker;
      crcAcc    <= '1;
    end else if (strobe.loadBeat) begin
      crcAcc    <= crcNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outLast  <= 1'b0;
      outMty   <= '0;
      outCrc   <= '0;
    end else if (strobe.loadBeat) begin
      outValid <= 1'b1;
      outData  <= strobe.zeroBeat ? '0 : inData;
      outLast  <= strobe.beatLast;
      outCrc   <= ~crcNext;
      if (strobe.zeroBeat) outMty <= MTY_W'(BYTES - 1);
      else if (strobe.beatLast) outMty <= MTY_W'(BYTES - int'(nBytes));
      else outMty <= '0;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // R1: a stalled beat keeps every output steady
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLast)
      && $stable(outMty) && $stable(outCrc) && $stable(outEcc));

  // R4: empty bytes only appear on the final beat
  assert_mty_last_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outLast |-> outMty == '0);

  // R5: zero-length packet is one empty final beat with the empty-message CRC
  assert_zero_beat_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && (outLen == '0) |-> outLast && (outMty == MTY_W'(BYTES - 1)) && (outCrc == '0));

  // R7: sideband fields do not move inside a packet
  assert_side_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outLast |=> $stable({outLen, outQid, outPort, outCmpt, outMarker}));

  // R10: no request is taken while a beat is on offer
  assert_no_load_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> !$past(strobe.loadReq));

endmodule

// File: rtl/c2h_framer.sv
module c2h_framer
  import c2h_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int BUF_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  output logic              reqReject,
  input  logic [15:0]       reqLen,
  input  logic [11:0]       reqQid,
  input  logic [2:0]        reqPort,
  input  logic              reqCmpt,
  input  logic              reqMarker,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outLast,
  output logic [5:0]        outMty,
  output logic [31:0]       outCrc,
  output logic [15:0]       outLen,
  output logic [11:0]       outQid,
  output logic [2:0]        outPort,
  output logic              outCmpt,
  output logic              outMarker,
  output logic [6:0]        outEcc
);

  localparam int BYTES   = DATA_W / 8;
  localparam int MAX_LEN = 31 * BUF_BYTES;

  generate
    if (!(DATA_W == 64 || DATA_W == 128 || DATA_W == 256 || DATA_W == 512)) begin : gBadWidth
      $error("c2h_framer: DATA_W must be 64, 128, 256 or 512");
    end
  endgenerate

  strobe_t strobe;

  c2h_ctrl #(.BYTES(BYTES), .MAX_LEN(MAX_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
    .inValid(inValid), .outValid(outValid), .outReady(outReady),
    .reqReady(reqReady), .reqReject(reqReject), .inReady(inReady),
    .strobe(strobe)
  );

  c2h_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqLen(reqLen), .reqQid(reqQid),
    .reqPort(reqPort), .reqCmpt(reqCmpt), .reqMarker(reqMarker), .inData(inData),
    .outReady(outReady), .outValid(outValid), .outData(outData), .outLast(outLast),
    .outMty(outMty), .outCrc(outCrc), .outLen(outLen), .outQid(outQid),
    .outPort(outPort), .outCmpt(outCmpt), .outMarker(outMarker), .outEcc(outEcc)
  );

endmodule

// File: tb/tb_c2h_framer.sv
`timescale 1ns/1ps
module tb_c2h_framer;

  localparam int DW   = 64;
  localparam int B    = DW / 8;
  localparam int BUFB = 64;
  localparam int MAXL = 31 * BUFB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqReady, reqReject;
  logic [15:0] reqLen = '0;
  logic [11:0] reqQid = '0;
  logic [2:0]  reqPort = '0;
  logic reqCmpt = 1'b0, reqMarker = 1'b0;
  logic inValid = 1'b0, inReady;
  logic [DW-1:0] inData = '0;
  logic outValid, outReady = 1'b0;
  logic [DW-1:0] outData;
  logic outLast;
  logic [5:0] outMty;
  logic [31:0] outCrc;
  logic [15:0] outLen;
  logic [11:0] outQid;
  logic [2:0] outPort;
  logic outCmpt, outMarker;
  logic [6:0] outEcc;

  c2h_framer #(.DATA_W(DW), .BUF_BYTES(BUFB)) dut (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [15:0] len; logic [11:0] qid; logic [2:0] port;
    logic cmpt; logic marker; bit reject;
  } req_t;

  typedef struct {
    logic [DW-1:0] data; logic [DW-1:0] mask; logic last;
    logic [5:0] mty; logic [31:0] crc;
    logic [15:0] len; logic [11:0] qid; logic [2:0] port;
    logic cmpt; logic marker;
  } beat_t;

  req_t          reqQ[$];
  logic [DW-1:0] inQ[$];
  beat_t         expQ[$];

  int  nChecks = 0;
  int  nFails = 0;
  int  rdyPct = 100;
  bit  done = 1'b0;
  bit  running = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refCrcByte(input logic [31:0] c, input logic [7:0] v);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) r = (r[0] ^ v[b]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  // Syndrome formulation: XOR the positions of set word bits.
  function automatic logic [6:0] refEcc(input logic [56:0] w);
    int pos; logic [5:0] syn;
    pos = 1; syn = '0;
    for (int j = 0; j < 57; j++) begin
      pos++;
      while ((pos & (pos - 1)) == 0) pos++;
      if (w[j]) syn = syn ^ 6'(pos);
    end
    return {(^w) ^ (^syn), syn};
  endfunction

  task automatic addPacket(input int len, input logic [11:0] qid, input logic [2:0] port,
                           input logic cmpt, input logic marker);
    req_t r; beat_t e; logic [31:0] c; int nb; logic [DW-1:0] w;
    r.len = 16'(len); r.qid = qid; r.port = port; r.cmpt = cmpt; r.marker = marker;
    r.reject = (len > MAXL);
    reqQ.push_back(r);
    if (r.reject) return;
    nb = (len == 0) ? 1 : (len + B - 1) / B;
    c = 32'hFFFFFFFF;
    for (int bt = 0; bt < nb; bt++) begin
      for (int k = 0; k < DW / 32; k++) w[32*k +: 32] = $urandom;
      e.mask = '0;
      for (int k = 0; k < B; k++) begin
        if (bt * B + k < len) begin
          c = refCrcByte(c, w[8*k +: 8]);
          e.mask[8*k +: 8] = 8'hFF;
        end
      end
      if (len > 0) inQ.push_back(w);
      e.data = w; e.last = (bt == nb - 1);
      e.mty = !e.last ? 6'd0 : (len == 0) ? 6'(B - 1) : 6'(B - (len - bt * B));
      e.crc = ~c;
      e.len = r.len; e.qid = qid; e.port = port; e.cmpt = cmpt; e.marker = marker;
      expQ.push_back(e);
    end
  endtask

  // Driver and cycle-by-cycle comparator, acting at the falling edge.
  initial begin
    logic [DW-1:0] pData; logic pLast; logic [5:0] pMty; logic [31:0] pCrc;
    logic [6:0] pEcc; bit pStall;
    pStall = 0; pData = '0; pLast = 0; pMty = '0; pCrc = '0; pEcc = '0;
    forever begin
      @(negedge clk);
      if (!running) continue;
      outReady = ($urandom_range(0, 99) < rdyPct);
      reqValid = (reqQ.size() > 0);
      if (reqValid) begin
        reqLen = reqQ[0].len; reqQid = reqQ[0].qid; reqPort = reqQ[0].port;
        reqCmpt = reqQ[0].cmpt; reqMarker = reqQ[0].marker;
      end
      inValid = (inQ.size() > 0);
      if (inValid) inData = inQ[0];
      #1;
      if (pStall) begin
        check(outValid && outData == pData && outLast == pLast && outMty == pMty
              && outCrc == pCrc && outEcc == pEcc, "R1 hold under stall",
              {outValid, outData}, {1'b1, pData});
      end
      if (outValid) check(!reqReady, "R10 reqReady while beat pending", reqReady, 0);
      if (reqValid && reqReady) begin
        check(reqReject == reqQ[0].reject, "R9 reject flag", reqReject, reqQ[0].reject);
        void'(reqQ.pop_front());
      end
      if (inValid && inReady) void'(inQ.pop_front());
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(0, "R2 unexpected beat", outData, 0);
        end else begin
          beat_t e;
          e = expQ.pop_front();
          check((outData & e.mask) == (e.data & e.mask), "R3 data bytes", outData & e.mask, e.data & e.mask);
          check(outLast == e.last, "R2 last flag", outLast, e.last);
          check(outMty == e.mty, "R4 empty count", outMty, e.mty);
          if (e.last) check(outCrc == e.crc, "R6 crc", outCrc, e.crc);
          if (e.len == 0) check(outCrc == 32'h0, "R5 zero crc", outCrc, 0);
          check({outLen, outQid, outPort, outCmpt, outMarker} ==
                {e.len, e.qid, e.port, e.cmpt, e.marker}, "R7 sideband",
                {outLen, outQid, outPort, outCmpt, outMarker},
                {e.len, e.qid, e.port, e.cmpt, e.marker});
          check(outEcc == refEcc({24'b0, e.cmpt, e.marker, e.port, e.qid, e.len}), "R8 ecc",
                outEcc, refEcc({24'b0, e.cmpt, e.marker, e.port, e.qid, e.len}));
        end
      end
      pStall = outValid && !outReady;
      pData = outData; pLast = outLast; pMty = outMty; pCrc = outCrc; pEcc = outEcc;
    end
  end

  task automatic drain();
    int t;
    t = 0;
    while ((reqQ.size() > 0 || expQ.size() > 0) && t < 20000) begin
      @(posedge clk); t++;
    end
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!outValid, "R1 reset outValid", outValid, 0);
    check(reqReady, "R10 reset reqReady", reqReady, 1);
    check(!inReady && !reqReject, "R9 reset inReady/reqReject", {inReady, reqReject}, 0);
    running = 1'b1;

    // Boundary lengths, no back-pressure
    addPacket(0, 12'h001, 3'd1, 1'b1, 1'b0);   // R5
    addPacket(1, 12'h002, 3'd2, 1'b0, 1'b1);
    addPacket(B, 12'h003, 3'd3, 1'b1, 1'b1);
    addPacket(B + 1, 12'hABC, 3'd7, 1'b0, 1'b0);
    drain();

    // Random back-pressure, rejected request between accepted ones (R9)
    rdyPct = 40;
    addPacket(3 * B, 12'hFFF, 3'd0, 1'b1, 1'b0);
    addPacket(MAXL + 1, 12'h111, 3'd4, 1'b1, 1'b1);
    addPacket(5, 12'h222, 3'd5, 1'b0, 1'b1);
    addPacket(0, 12'h333, 3'd6, 1'b1, 1'b1);
    addPacket(65535, 12'h444, 3'd2, 1'b0, 1'b0);
    addPacket(2 * B - 1, 12'h555, 3'd1, 1'b1, 1'b0);
    drain();

    // Largest accepted length, then random mixes
    rdyPct = 70;
    addPacket(MAXL, 12'h7A5, 3'd3, 1'b0, 1'b1);
    for (int i = 0; i < 30; i++)
      addPacket($urandom_range(0, 4 * B + 3), 12'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
    drain();

    check(expQ.size() == 0 && reqQ.size() == 0, "R2 all beats delivered", expQ.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule